// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver with Cascade

This block decides which pending interrupt line, if any, is presented to the processor. It contains two resolver instances, a primary and a secondary, each serving eight lines. Each instance takes a request vector, a mask vector and an in-service vector. It ranks the unmasked requests under a 3-bit rotation offset and reports the winner, but only when that winner outranks the most important line already in service. The ranking starts at the line equal to the rotation offset, so with an offset of zero, line 0 is the most important. The rotation offset is held inside each instance. It can be loaded directly, or it can advance automatically when a line is acknowledged, so that the line just served drops to the lowest rank.

The secondary instance feeds the primary through the cascade line, which is line 2. When the secondary instance's pending flag rises, a request is latched on the primary's cascade line. That request stays latched until the primary acknowledges line 2. The primary's registered valid flag is the processor interrupt request. A nesting flag on the primary leaves the in-service cascade bit out of its comparison, so that further secondary requests can get through while an earlier secondary interrupt is still in service.

The request, mask and in-service vectors are plain inputs owned by the surrounding controller. Vector formation and register access are handled outside this block.

Top module: `irq_cascade_resolver`

## Requirements
- R1: A line takes part in resolution only when its request bit is 1 and its mask bit is 0. A masked line is never reported.
- R2: A line's rank is (line - rotation) mod 8, and rank 0 is the most important. The reported line is the unmasked request with the lowest rank. With rotation 4, line 5 beats line 3. With rotation 6, line 7 beats line 0.
- R3: A winning request is reported only when its rank is strictly lower than the lowest rank among the set in-service bits, using the same rotation. Equal rank means no report. An empty in-service vector lets any candidate through.
- R4: When the nesting flag is 1, the primary excludes in-service bit 2 from the R3 comparison. Its other in-service bits still count. The secondary always counts all of its in-service bits, whatever the nesting flag says.
- R5: The valid flag and the line number are registered. They reflect the inputs present one clock edge earlier.
- R6: A load strobe sets the instance's rotation to the load value at the next edge. A load takes precedence over an acknowledge in the same cycle.
- R7: An acknowledge with auto-rotation enabled sets the rotation to (acknowledged line + 1) mod 8. An acknowledge with auto-rotation disabled leaves the rotation unchanged.
- R8: Bit 2 of the primary request input is ignored. The primary's line 2 request is instead a latch. The latch is set one edge after the secondary's valid flag rises, and it is cleared by a primary acknowledge of line 2. Setting wins over clearing in the same cycle. A secondary request that stays pending does not set the latch again.
- R9: After reset, both valid flags are 0, the line numbers and both rotations are 0, and the cascade latch is clear.
- R10: When no unmasked request exists, the valid flag is 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 8 | Primary request vector (bit 2 ignored) |
| m_mask | input | 8 | Primary mask vector, 1 = masked |
| m_isr | input | 8 | Primary in-service vector |
| m_nest | input | 1 | Nesting flag: exclude in-service cascade bit on the primary |
| m_rot_load | input | 1 | Primary rotation load strobe |
| m_rot_val | input | 3 | Primary rotation load value |
| m_auto_rot | input | 1 | Primary auto-rotation on acknowledge |
| m_ack | input | 1 | Primary acknowledge strobe |
| m_ack_line | input | 3 | Line acknowledged on the primary |
| s_req | input | 8 | Secondary request vector |
| s_mask | input | 8 | Secondary mask vector |
| s_isr | input | 8 | Secondary in-service vector |
| s_rot_load | input | 1 | Secondary rotation load strobe |
| s_rot_val | input | 3 | Secondary rotation load value |
| s_auto_rot | input | 1 | Secondary auto-rotation on acknowledge |
| s_ack | input | 1 | Secondary acknowledge strobe |
| s_ack_line | input | 3 | Line acknowledged on the secondary |
| cpu_irq | output | 1 | Primary valid flag, the processor interrupt request |
| m_line | output | 3 | Primary winning line |
| s_valid | output | 1 | Secondary valid flag |
| s_line | output | 3 | Secondary winning line |
| m_rot | output | 3 | Primary rotation offset |
| s_rot | output | 3 | Secondary rotation offset |

## Verification
The bench builds the block with its defaults: eight lines per instance and the cascade on line 2. With eight lines, every rotation value can be reached. That includes the wrap where the most important line sits just above the least important one (for example rotation 6 ranking line 7 above line 0), and the auto-rotation wrap from line 7 to offset 0. With the cascade on line 2, a single in-service bit shows the nesting exemption on the primary and its absence on the secondary. The same setup shows the cascade latch's edge behaviour while a secondary request stays pending.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
    // Default geometry shared by the resolver modules
    localparam int DEF_LINES     = 8;
    localparam int DEF_CASC_LINE = 2;
endpackage

// File: rtl/rot_prio_search.sv
module rot_prio_search #(
    parameter int LINES = irq_res_pkg::DEF_LINES,
    localparam int IW   = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    input  logic [IW-1:0]    rot,
    output logic             found,
    output logic [IW-1:0]    rank
);
    // LINES must be a power of two so the index sum wraps naturally
    logic [IW-1:0] idx;

    always_comb begin
        found = 1'b0;
        rank  = '0;
        idx   = '0;
        // walk from least to most important so the lowest rank is kept
        for (int p = LINES - 1; p >= 0; p--) begin
            idx = IW'(p) + rot;
            if (vec[idx]) begin
                found = 1'b1;
                rank  = IW'(p);
            end
        end
    end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
    parameter int LINES     = irq_res_pkg::DEF_LINES,
    parameter int CASC_LINE = irq_res_pkg::DEF_CASC_LINE,
    parameter bit IS_MASTER = 1'b0,
    localparam int IW       = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] isr,
    input  logic             nest,
    input  logic             rot_load,
    input  logic [IW-1:0]    rot_val,
    input  logic             auto_rot,
    input  logic             ack,
    input  logic [IW-1:0]    ack_line,
    output logic             valid,
    output logic [IW-1:0]    line,
    output logic [IW-1:0]    rot
);
    localparam logic [LINES-1:0] ONE = {{(LINES-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          valid;
        logic [IW-1:0] line;
        logic [IW-1:0] rot;
    } res_t;

    res_t st_d, st_q;

    logic [LINES-1:0] cand;
    logic [LINES-1:0] isr_eff;
    logic [LINES-1:0] excl_bit;
    logic             r_found, i_found;
    logic [IW-1:0]    r_rank, i_rank;

    // only the primary may drop its cascade bit from the comparison
    if (IS_MASTER) begin : g_excl
        assign excl_bit = ONE << CASC_LINE;
    end else begin : g_noexcl
        assign excl_bit = '0;
    end

    assign cand    = req & ~mask;
    assign isr_eff = nest ? (isr & ~excl_bit) : isr;

    rot_prio_search #(.LINES(LINES)) u_req_search (
        .vec   (cand),
        .rot   (st_q.rot),
        .found (r_found),
        .rank  (r_rank)
    );

    rot_prio_search #(.LINES(LINES)) u_isr_search (
        .vec   (isr_eff),
        .rot   (st_q.rot),
        .found (i_found),
        .rank  (i_rank)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = r_found && (!i_found || (r_rank < i_rank));
        st_d.line  = st_d.valid ? (r_rank + st_q.rot) : '0;
        if (rot_load) begin
            st_d.rot = rot_val;
        end else if (ack && auto_rot) begin
            st_d.rot = ack_line + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign line  = st_q.line;
    assign rot   = st_q.rot;

    // R1
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> ((($past(cand) >> st_q.line) & ONE) != '0));

    // R10
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |=> !st_q.valid);

    // R6
    rot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot_load |=> (st_q.rot == $past(rot_val)));

    // R7
    rot_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_rot && !rot_load) |=> (st_q.rot == IW'($past(ack_line) + 1'b1)));

    // R7
    rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_load && !(ack && auto_rot)) |=> $stable(st_q.rot));
endmodule

// File: rtl/irq_cascade_resolver.sv
module irq_cascade_resolver #(
    parameter int LINES     = irq_res_pkg::DEF_LINES,
    parameter int CASC_LINE = irq_res_pkg::DEF_CASC_LINE,
    localparam int IW       = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] m_req,
    input  logic [LINES-1:0] m_mask,
    input  logic [LINES-1:0] m_isr,
    input  logic             m_nest,
    input  logic             m_rot_load,
    input  logic [IW-1:0]    m_rot_val,
    input  logic             m_auto_rot,
    input  logic             m_ack,
    input  logic [IW-1:0]    m_ack_line,
    input  logic [LINES-1:0] s_req,
    input  logic [LINES-1:0] s_mask,
    input  logic [LINES-1:0] s_isr,
    input  logic             s_rot_load,
    input  logic [IW-1:0]    s_rot_val,
    input  logic             s_auto_rot,
    input  logic             s_ack,
    input  logic [IW-1:0]    s_ack_line,
    output logic             cpu_irq,
    output logic [IW-1:0]    m_line,
    output logic             s_valid,
    output logic [IW-1:0]    s_line,
    output logic [IW-1:0]    m_rot,
    output logic [IW-1:0]    s_rot
);
    localparam logic [LINES-1:0] CASC_BIT = {{(LINES-1){1'b0}}, 1'b1} << CASC_LINE;

    typedef struct packed {
        logic casc;
        logic s_prev;
    } casc_t;

    casc_t cs_d, cs_q;

    logic [LINES-1:0] m_req_eff;
    logic             casc_ack;

    assign casc_ack  = m_ack && (m_ack_line == IW'(CASC_LINE));
    assign m_req_eff = (m_req & ~CASC_BIT) | (cs_q.casc ? CASC_BIT : '0);

    always_comb begin
        cs_d        = cs_q;
        cs_d.s_prev = s_valid;
        cs_d.casc   = (cs_q.casc && !casc_ack) || (s_valid && !cs_q.s_prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    prio_resolver #(.LINES(LINES), .CASC_LINE(CASC_LINE), .IS_MASTER(1'b0)) u_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (s_req),
        .mask     (s_mask),
        .isr      (s_isr),
        .nest     (m_nest),
        .rot_load (s_rot_load),
        .rot_val  (s_rot_val),
        .auto_rot (s_auto_rot),
        .ack      (s_ack),
        .ack_line (s_ack_line),
        .valid    (s_valid),
        .line     (s_line),
        .rot      (s_rot)
    );

    prio_resolver #(.LINES(LINES), .CASC_LINE(CASC_LINE), .IS_MASTER(1'b1)) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (m_req_eff),
        .mask     (m_mask),
        .isr      (m_isr),
        .nest     (m_nest),
        .rot_load (m_rot_load),
        .rot_val  (m_rot_val),
        .auto_rot (m_auto_rot),
        .ack      (m_ack),
        .ack_line (m_ack_line),
        .valid    (cpu_irq),
        .line     (m_line),
        .rot      (m_rot)
    );

    // R8
    casc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_valid) |=> m_req_eff[CASC_LINE]);

    // R8
    casc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_ack && !$rose(s_valid)) |=> !m_req_eff[CASC_LINE]);
endmodule

// File: tb/tb_irq_cascade_resolver.sv
module tb_irq_cascade_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] m_req = '0, m_mask = '0, m_isr = '0;
    logic       m_nest = 1'b0, m_rot_load = 1'b0, m_auto_rot = 1'b0, m_ack = 1'b0;
    logic [2:0] m_rot_val = '0, m_ack_line = '0;
    logic [7:0] s_req = '0, s_mask = '0, s_isr = '0;
    logic       s_rot_load = 1'b0, s_auto_rot = 1'b0, s_ack = 1'b0;
    logic [2:0] s_rot_val = '0, s_ack_line = '0;
    logic       cpu_irq, s_valid;
    logic [2:0] m_line, s_line, m_rot, s_rot;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_cascade_resolver dut (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_mask(m_mask), .m_isr(m_isr), .m_nest(m_nest),
        .m_rot_load(m_rot_load), .m_rot_val(m_rot_val), .m_auto_rot(m_auto_rot),
        .m_ack(m_ack), .m_ack_line(m_ack_line),
        .s_req(s_req), .s_mask(s_mask), .s_isr(s_isr),
        .s_rot_load(s_rot_load), .s_rot_val(s_rot_val), .s_auto_rot(s_auto_rot),
        .s_ack(s_ack), .s_ack_line(s_ack_line),
        .cpu_irq(cpu_irq), .m_line(m_line), .s_valid(s_valid), .s_line(s_line),
        .m_rot(m_rot), .s_rot(s_rot)
    );

    // row: {rot[3], req[8], mask[8], isr[8], nest, exp_valid, exp_line[3]}
    localparam logic [31:0] TBL [14] = '{
        {3'd0, 8'h28, 8'h00, 8'h00, 1'b0, 1'b1, 3'd3},  // R2 plain order
        {3'd0, 8'h28, 8'h08, 8'h00, 1'b0, 1'b1, 3'd5},  // R1 mask skips line 3
        {3'd0, 8'h28, 8'h28, 8'h00, 1'b0, 1'b0, 3'd0},  // R1 R10 all masked
        {3'd4, 8'h28, 8'h00, 8'h00, 1'b0, 1'b1, 3'd5},  // R2 rotation 4
        {3'd6, 8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 3'd7},  // R2 wrap
        {3'd0, 8'h20, 8'h00, 8'h20, 1'b0, 1'b0, 3'd0},  // R3 equal rank
        {3'd0, 8'h10, 8'h00, 8'h20, 1'b0, 1'b1, 3'd4},  // R3 outranks
        {3'd0, 8'h40, 8'h00, 8'h20, 1'b0, 1'b0, 3'd0},  // R3 below
        {3'd0, 8'h08, 8'h00, 8'h04, 1'b0, 1'b0, 3'd0},  // R4 no nesting
        {3'd0, 8'h08, 8'h00, 8'h04, 1'b1, 1'b1, 3'd3},  // R4 nesting exempts bit 2
        {3'd0, 8'h08, 8'h00, 8'h06, 1'b1, 1'b0, 3'd0},  // R4 other bits still count
        {3'd3, 8'h04, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0},  // R8 input bit 2 ignored
        {3'd5, 8'h02, 8'h00, 8'h80, 1'b0, 1'b0, 3'd0},  // R3 rotated in-service
        {3'd5, 8'h80, 8'h00, 8'h02, 1'b0, 1'b1, 3'd7}   // R3 rotated win
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_req = '0; m_mask = '0; m_isr = '0; m_nest = 1'b0;
        m_rot_load = 1'b0; m_auto_rot = 1'b0; m_ack = 1'b0;
        s_req = '0; s_mask = '0; s_isr = '0;
        s_rot_load = 1'b0; s_auto_rot = 1'b0; s_ack = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // table walk
        for (int i = 0; i < 14; i++) begin
            do_reset();
            m_req  = TBL[i][28:21];
            m_mask = TBL[i][20:13];
            m_isr  = TBL[i][12:5];
            m_nest = TBL[i][4];
            m_rot_load = 1'b1;
            m_rot_val  = TBL[i][31:29];
            @(negedge clk);
            m_rot_load = 1'b0;
            repeat (2) @(negedge clk);
            chk(cpu_irq == TBL[i][3], $sformatf("R1/R2/R3/R4/R8/R10 row %0d valid", i),
                int'(cpu_irq), int'(TBL[i][3]));
            if (TBL[i][3])
                chk(m_line == TBL[i][2:0], $sformatf("R2 row %0d line", i),
                    int'(m_line), int'(TBL[i][2:0]));
        end

        // R9 reset state, with a rotation loaded beforehand
        do_reset();
        m_rot_load = 1'b1; m_rot_val = 3'd5; s_rot_load = 1'b1; s_rot_val = 3'd3;
        @(negedge clk);
        m_rot_load = 1'b0; s_rot_load = 1'b0;
        do_reset();
        chk(cpu_irq == 1'b0, "R9 cpu_irq", int'(cpu_irq), 0);
        chk(s_valid == 1'b0, "R9 s_valid", int'(s_valid), 0);
        chk(m_line == 3'd0, "R9 m_line", int'(m_line), 0);
        chk(m_rot == 3'd0, "R9 m_rot", int'(m_rot), 0);
        chk(s_rot == 3'd0, "R9 s_rot", int'(s_rot), 0);

        // R5 one-edge latency
        @(negedge clk);
        m_req = 8'h01;
        #1;
        chk(cpu_irq == 1'b0, "R5 before edge", int'(cpu_irq), 0);
        @(negedge clk);
        chk(cpu_irq == 1'b1, "R5 after one edge", int'(cpu_irq), 1);

        // R6 load, and load over acknowledge
        m_rot_load = 1'b1; m_rot_val = 3'd5;
        @(negedge clk);
        m_rot_load = 1'b0;
        chk(m_rot == 3'd5, "R6 load", int'(m_rot), 5);
        m_rot_load = 1'b1; m_rot_val = 3'd1;
        m_ack = 1'b1; m_ack_line = 3'd6; m_auto_rot = 1'b1;
        @(negedge clk);
        m_rot_load = 1'b0; m_ack = 1'b0;
        chk(m_rot == 3'd1, "R6 load beats ack", int'(m_rot), 1);

        // R7 auto-rotation wrap, disabled hold, secondary rotation
        m_ack = 1'b1; m_ack_line = 3'd7; m_auto_rot = 1'b1;
        @(negedge clk);
        m_ack = 1'b0;
        chk(m_rot == 3'd0, "R7 wrap to 0", int'(m_rot), 0);
        m_rot_load = 1'b1; m_rot_val = 3'd6;
        @(negedge clk);
        m_rot_load = 1'b0;
        m_ack = 1'b1; m_ack_line = 3'd3; m_auto_rot = 1'b0;
        @(negedge clk);
        m_ack = 1'b0;
        chk(m_rot == 3'd6, "R7 hold when disabled", int'(m_rot), 6);
        s_ack = 1'b1; s_ack_line = 3'd4; s_auto_rot = 1'b1;
        @(negedge clk);
        s_ack = 1'b0;
        chk(s_rot == 3'd5, "R7 secondary rotation", int'(s_rot), 5);

        // R8 cascade latch timing and clearing
        do_reset();
        s_req = 8'h20;
        @(negedge clk);
        chk(s_valid == 1'b1, "R8 secondary valid", int'(s_valid), 1);
        chk(cpu_irq == 1'b0, "R8 not yet at edge 1", int'(cpu_irq), 0);
        @(negedge clk);
        chk(cpu_irq == 1'b0, "R8 not yet at edge 2", int'(cpu_irq), 0);
        @(negedge clk);
        chk(cpu_irq == 1'b1, "R8 cascade raises cpu_irq", int'(cpu_irq), 1);
        chk(m_line == 3'd2, "R8 cascade line", int'(m_line), 2);
        chk(s_line == 3'd5, "R2 secondary line", int'(s_line), 5);
        m_ack = 1'b1; m_ack_line = 3'd2;
        @(negedge clk);
        m_ack = 1'b0;
        repeat (2) @(negedge clk);
        chk(cpu_irq == 1'b0, "R8 ack clears, no re-set while pending", int'(cpu_irq), 0);
        chk(s_valid == 1'b1, "R8 secondary still pending", int'(s_valid), 1);

        // R4 secondary counts its in-service bit 2 even with nesting set
        do_reset();
        m_nest = 1'b1; s_isr = 8'h04; s_req = 8'h20;
        repeat (3) @(negedge clk);
        chk(s_valid == 1'b0, "R4 secondary no exemption", int'(s_valid), 0);
        s_isr = 8'h40;
        repeat (2) @(negedge clk);
        chk(s_valid == 1'b1, "R3 secondary outranks", int'(s_valid), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule